// File: doc/BRIEF.md
# Hot-Swap Insertion Power Sequencer

This block is the digital decision-maker for a plug-in board's supply switches. It watches two active-low connection-sense inputs, an active-low power-down request, two overcurrent comparator flags (one per supply), a flag saying both outputs have discharged below the restart level, and an undervoltage-lockout flag. From these it decides when the external gate charge pumps may run (`pump_en`), when the gates must be actively pulled down (`gate_pd`), and when a breaker fault is reported (`fault_n`).

Every asynchronous input passes through a two-flop synchroniser. Three hold timers, each counting clock cycles, give the time windows. The first qualifies insertion. The second qualifies a long power-down request. The third filters out short overcurrent glitches, and it is built twice, once for each supply. The window lengths are parameters. A tripped breaker stays latched until the power-down request input is pulled low. After a long request, the block does not start again until the request has been released and the outputs have discharged.

Top module: `hotswap_seq`

## Requirements
- R1: `pump_en` rises only after `con_a_n` and `con_b_n` have both been low together for `QUAL_CYC` cycles. If either input goes high, the count starts again from zero. With the bench values, the rise falls on the 43rd rising edge after the second input goes low: two synchroniser stages, `QUAL_CYC` = 40 counting edges, and one state edge.
- R2: When either connection input goes high while `pump_en` is high, `pump_en` is low and `gate_pd` is high by the third rising edge. No debounce is applied.
- R3: Holding `por_req_n` low for `POR_CYC` cycles powers the board down: `pump_en` goes low and `gate_pd` goes high. A shorter low pulse leaves a powered board on.
- R4: `pump_en` never rises while `por_req_n` is low.
- R5: After a full power-down request is released, `pump_en` stays low until `out_below_trip` is high. Power-up then resumes without a new insertion qualification if the connection inputs stayed low.
- R6: A trip needs `oc_lo` or `oc_hi` to be high continuously for `OC_CYC` cycles. Shorter pulses leave `fault_n`, `pump_en` and `gate_pd` unchanged.
- R7: On a trip, `fault_n` falls, `pump_en` falls and `gate_pd` rises on the same clock edge.
- R8: `fault_n` stays low after the overcurrent flag clears. It returns high only after `por_req_n` has been pulled low. After the fault clears, the restart follows R5.
- R9: While `uvlo` is high, `pump_en` is low and `gate_pd` is high. The drop takes effect by the third rising edge. Insertion qualification starts again once `uvlo` clears.
- R10: A low `rst_n` at a clock edge sets the off state: `pump_en` low, `gate_pd` high, `fault_n` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| con_a_n | input | 1 | Connection sense A, low when seated |
| con_b_n | input | 1 | Connection sense B, low when seated |
| por_req_n | input | 1 | Power-down / fault-clear request, active low |
| oc_lo | input | 1 | Overcurrent flag, low-voltage supply |
| oc_hi | input | 1 | Overcurrent flag, high-voltage supply |
| out_below_trip | input | 1 | Both outputs discharged below restart level |
| uvlo | input | 1 | Undervoltage lockout active |
| pump_en | output | 1 | Charge pump enable (ramp start) |
| fault_n | output | 1 | Breaker tripped, active low |
| gate_pd | output | 1 | Gate pulldown request |

## Verification
The assertions assume that the inputs change at most once per clock period and are sampled cleanly, so that a run of high or low samples in the checker matches what the synchronisers see. They also assume `por_req_n` is high while `rst_n` is low. The bench changes every input one time unit after a rising edge and releases reset with `por_req_n` high. It also holds each level for whole cycle counts, so the counted runs in the checker line up with the synchronised view.

// File: rtl/hotswap_pkg.sv
// Shared types for the hot-swap power sequencer.
// Assumes: consumers import the package before using the state type.
package hotswap_pkg;

    // Controller states; ST_DRAIN waits for request release and discharge.
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ON    = 2'd1,
        ST_FAULT = 2'd2,
        ST_DRAIN = 2'd3
    } hs_state_t;

    // Bit positions inside the synchronised input vector.
    localparam int IDX_CON_A = 0;
    localparam int IDX_CON_B = 1;
    localparam int IDX_POR   = 2;
    localparam int IDX_OC_LO = 3;
    localparam int IDX_OC_HI = 4;
    localparam int IDX_BELOW = 5;
    localparam int IDX_UVLO  = 6;
    localparam int N_INPUTS  = 7;

endpackage

// File: rtl/hs_sync.sv
// Two-flop synchroniser for a vector of independent asynchronous levels.
// Assumes: each bit is a slow level; no bus coherency is needed across bits.
module hs_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] q_sync
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages per bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d_async;
            stab_q <= meta_q;
        end
    end

    assign q_sync = stab_q;

endmodule

// File: rtl/hs_hold_timer.sv
// Continuous-hold qualifier: held_o goes high once active_i has been high
// for LEN consecutive clock cycles, and drops as soon as active_i drops.
// Assumes: active_i is already synchronous; LEN >= 1.
module hs_hold_timer #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    output logic held_o
);

    localparam int CW = $clog2(LEN + 1);
    localparam logic [CW-1:0] CMAX = CW'(LEN);

    logic [CW-1:0] cnt_q;

    // Count consecutive active cycles, saturating at LEN, clear on inactive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!active_i) begin
            cnt_q <= '0;
        end else if (cnt_q != CMAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign held_o = active_i && (cnt_q == CMAX);

endmodule

// File: rtl/hs_fault_latch.sv
// Sticky breaker fault flag: set by a trip event, cleared by a clear level.
// Assumes: clear has priority, so a trip while clearing is dropped; the
// caller only presents trips while the supplies are on.
module hs_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic fault_o
);

    logic fault_q;

    // Hold the fault until an explicit clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= 1'b0;
        end else if (clr_i) begin
            fault_q <= 1'b0;
        end else if (set_i) begin
            fault_q <= 1'b1;
        end
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/hotswap_seq.sv
// Hot-swap insertion power sequencer. Qualifies board insertion, sequences
// pump enable and gate pulldown, filters and latches overcurrent trips, and
// blocks restart until a power-down request is released and outputs drained.
// Assumes: all inputs asynchronous levels; window parameters in clock cycles.
module hotswap_seq
    import hotswap_pkg::*;
#(
    parameter int QUAL_CYC = 5000000,
    parameter int POR_CYC  = 5000000,
    parameter int OC_CYC   = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic con_a_n,
    input  logic con_b_n,
    input  logic por_req_n,
    input  logic oc_lo,
    input  logic oc_hi,
    input  logic out_below_trip,
    input  logic uvlo,
    output logic pump_en,
    output logic fault_n,
    output logic gate_pd
);

    localparam logic [N_INPUTS-1:0] SYNC_RST = 7'b100_0111;
    localparam int N_SUPPLY = 2;

    logic [N_INPUTS-1:0] raw_in;
    logic [N_INPUTS-1:0] syn;
    logic                conn_ok;
    logic                por_long;
    logic [N_SUPPLY-1:0] oc_syn;
    logic [N_SUPPLY-1:0] oc_held;
    logic                trip_any;
    logic                trip_evt;
    logic                fault_q;
    logic                con_lost;
    hs_state_t           state_q;
    hs_state_t           state_d;

    assign raw_in = {uvlo, out_below_trip, oc_hi, oc_lo, por_req_n, con_b_n, con_a_n};

    hs_sync #(.W(N_INPUTS), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (raw_in),
        .q_sync  (syn)
    );

    // Insertion qualifier: both pins low and supplies above lockout.
    hs_hold_timer #(.LEN(QUAL_CYC)) u_conn_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (!syn[IDX_CON_A] && !syn[IDX_CON_B] && !syn[IDX_UVLO]),
        .held_o   (conn_ok)
    );

    // Long power-down request qualifier.
    hs_hold_timer #(.LEN(POR_CYC)) u_por_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (!syn[IDX_POR]),
        .held_o   (por_long)
    );

    assign oc_syn = {syn[IDX_OC_HI], syn[IDX_OC_LO]};

    // One glitch filter per supply.
    for (genvar g = 0; g < N_SUPPLY; g++) begin : g_oc
        hs_hold_timer #(.LEN(OC_CYC)) u_oc_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (oc_syn[g]),
            .held_o   (oc_held[g])
        );
    end

    assign trip_any = |oc_held;
    assign trip_evt = trip_any && (state_q == ST_ON);
    assign con_lost = syn[IDX_CON_A] || syn[IDX_CON_B];

    hs_fault_latch u_fault (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (trip_evt),
        .clr_i   (!syn[IDX_POR]),
        .fault_o (fault_q)
    );

    // Next-state decision; trip outranks lockout, which outranks requests.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (syn[IDX_UVLO]) begin
                    state_d = ST_OFF;
                end else if (por_long) begin
                    state_d = ST_DRAIN;
                end else if (conn_ok && syn[IDX_POR] && !fault_q) begin
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (trip_any) begin
                    state_d = ST_FAULT;
                end else if (syn[IDX_UVLO]) begin
                    state_d = ST_OFF;
                end else if (por_long) begin
                    state_d = ST_DRAIN;
                end else if (con_lost) begin
                    state_d = ST_OFF;
                end
            end
            ST_FAULT: begin
                if (!fault_q) begin
                    state_d = ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (syn[IDX_POR] && syn[IDX_BELOW]) begin
                    state_d = ST_OFF;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    assign pump_en = (state_q == ST_ON);
    assign gate_pd = (state_q != ST_ON);
    assign fault_n = !fault_q;

endmodule

// File: rtl/hotswap_seq_chk.sv
// Port-level checker for hotswap_seq, bound to every instance of the top.
// Assumes: inputs change at most once per cycle, por_req_n high in reset.
module hotswap_seq_chk #(
    parameter int QUAL_CYC = 16,
    parameter int OC_CYC   = 8
) (
    input logic clk,
    input logic rst_n,
    input logic con_a_n,
    input logic con_b_n,
    input logic por_req_n,
    input logic oc_lo,
    input logic oc_hi,
    input logic uvlo,
    input logic pump_en,
    input logic fault_n,
    input logic gate_pd
);

    localparam int unsigned CAP = 32'h7fff_ffff;

    int unsigned seat_run;
    int unsigned unseat_run;
    int unsigned por_low_run;
    int unsigned uvlo_run;
    int unsigned oc_lo_len;
    int unsigned oc_hi_len;
    int unsigned oc_lo_gap;
    int unsigned oc_hi_gap;

    // Run-length trackers over the raw inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seat_run    <= 0;
            unseat_run  <= 0;
            por_low_run <= 0;
            uvlo_run    <= 0;
            oc_lo_len   <= 0;
            oc_hi_len   <= 0;
            oc_lo_gap   <= 0;
            oc_hi_gap   <= 0;
        end else begin
            seat_run    <= (!con_a_n && !con_b_n) ? ((seat_run < CAP) ? seat_run + 1 : CAP) : 0;
            unseat_run  <= (con_a_n || con_b_n) ? ((unseat_run < CAP) ? unseat_run + 1 : CAP) : 0;
            por_low_run <= !por_req_n ? ((por_low_run < CAP) ? por_low_run + 1 : CAP) : 0;
            uvlo_run    <= uvlo ? ((uvlo_run < CAP) ? uvlo_run + 1 : CAP) : 0;
            if (oc_lo) begin
                oc_lo_len <= (oc_lo_len < CAP) ? oc_lo_len + 1 : CAP;
                oc_lo_gap <= 0;
            end else begin
                oc_lo_gap <= (oc_lo_gap < 8) ? oc_lo_gap + 1 : 8;
                if (oc_lo_gap >= 3) oc_lo_len <= 0;
            end
            if (oc_hi) begin
                oc_hi_len <= (oc_hi_len < CAP) ? oc_hi_len + 1 : CAP;
                oc_hi_gap <= 0;
            end else begin
                oc_hi_gap <= (oc_hi_gap < 8) ? oc_hi_gap + 1 : 8;
                if (oc_hi_gap >= 3) oc_hi_len <= 0;
            end
        end
    end

    p_qual_before_pump_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pump_en) |-> (seat_run >= QUAL_CYC));

    p_unseat_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (unseat_run >= 3) |-> (!pump_en && gate_pd));

    p_no_start_in_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (por_low_run >= 3) |-> !$rose(pump_en));

    p_oc_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> ((oc_lo_len >= OC_CYC) || (oc_hi_len >= OC_CYC)));

    p_trip_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_n) |-> (!pump_en && gate_pd));

    p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_n && por_req_n && $past(por_req_n)) |=> !fault_n);

    p_uvlo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uvlo_run >= 3) |-> (!pump_en && gate_pd));

    p_fault_blocks_pump_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_n |-> !pump_en);

endmodule

bind hotswap_seq hotswap_seq_chk #(
    .QUAL_CYC (QUAL_CYC),
    .OC_CYC   (OC_CYC)
) u_hotswap_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .con_a_n   (con_a_n),
    .con_b_n   (con_b_n),
    .por_req_n (por_req_n),
    .oc_lo     (oc_lo),
    .oc_hi     (oc_hi),
    .uvlo      (uvlo),
    .pump_en   (pump_en),
    .fault_n   (fault_n),
    .gate_pd   (gate_pd)
);

// File: tb/test_hotswap_seq.sv
module test_hotswap_seq;

    localparam int QUAL = 40;
    localparam int PORW = 30;
    localparam int OCW  = 8;
    localparam time TCLK = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic con_a_n = 1'b1;
    logic con_b_n = 1'b1;
    logic por_req_n = 1'b1;
    logic oc_lo = 1'b0;
    logic oc_hi = 1'b0;
    logic out_below_trip = 1'b0;
    logic uvlo = 1'b0;
    logic pump_en;
    logic fault_n;
    logic gate_pd;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(TCLK / 2) clk = ~clk;

    hotswap_seq #(.QUAL_CYC(QUAL), .POR_CYC(PORW), .OC_CYC(OCW)) i_hotswap_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .con_a_n        (con_a_n),
        .con_b_n        (con_b_n),
        .por_req_n      (por_req_n),
        .oc_lo          (oc_lo),
        .oc_hi          (oc_hi),
        .out_below_trip (out_below_trip),
        .uvlo           (uvlo),
        .pump_en        (pump_en),
        .fault_n        (fault_n),
        .gate_pd        (gate_pd)
    );

    // Advance n rising edges, then settle one time unit past the edge.
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic t_reset_r10();
        rst_n = 1'b0;
        step(3);
        chk("R10", "pump_en in reset", pump_en, 1'b0);
        chk("R10", "gate_pd in reset", gate_pd, 1'b1);
        chk("R10", "fault_n in reset", fault_n, 1'b1);
        rst_n = 1'b1;
        step(2);
        chk("R10", "pump_en after reset", pump_en, 1'b0);
    endtask

    task automatic t_insert_r1();
        con_a_n = 1'b0;
        step(60);
        chk("R1", "one pin only", pump_en, 1'b0);
        con_b_n = 1'b0;
        step(20);
        con_b_n = 1'b1;
        step(2);
        con_b_n = 1'b0;
        step(35);
        chk("R1", "restarted window not yet done", pump_en, 1'b0);
        step(8);
        chk("R1", "qualified after full window", pump_en, 1'b1);
        chk("R1", "gate_pd released", gate_pd, 1'b0);
    endtask

    task automatic t_remove_r2();
        con_a_n = 1'b1;
        step(3);
        chk("R2", "pump_en after unseat", pump_en, 1'b0);
        chk("R2", "gate_pd after unseat", gate_pd, 1'b1);
        con_a_n = 1'b0;
        step(48);
        chk("R2", "requalified", pump_en, 1'b1);
    endtask

    task automatic t_oc_glitch_r6();
        oc_lo = 1'b1;
        step(4);
        oc_lo = 1'b0;
        step(2);
        oc_hi = 1'b1;
        step(5);
        oc_hi = 1'b0;
        step(20);
        chk("R6", "fault_n after short pulses", fault_n, 1'b1);
        chk("R6", "pump_en after short pulses", pump_en, 1'b1);
    endtask

    task automatic t_oc_trip_r7_r8();
        oc_hi = 1'b1;
        step(8);
        chk("R6", "fault_n before window", fault_n, 1'b1);
        step(6);
        chk("R7", "fault_n after trip", fault_n, 1'b0);
        chk("R7", "pump_en after trip", pump_en, 1'b0);
        chk("R7", "gate_pd after trip", gate_pd, 1'b1);
        oc_hi = 1'b0;
        con_a_n = 1'b1;
        step(4);
        con_a_n = 1'b0;
        step(60);
        chk("R8", "fault_n held", fault_n, 1'b0);
        chk("R8", "pump_en held off", pump_en, 1'b0);
        out_below_trip = 1'b1;
        por_req_n = 1'b0;
        step(5);
        por_req_n = 1'b1;
        step(12);
        chk("R8", "fault_n cleared", fault_n, 1'b1);
        chk("R8", "restart after clear", pump_en, 1'b1);
    endtask

    task automatic t_por_short_r3();
        por_req_n = 1'b0;
        step(10);
        por_req_n = 1'b1;
        step(6);
        chk("R3", "short request ignored", pump_en, 1'b1);
    endtask

    task automatic t_por_long_r3_r4_r5();
        out_below_trip = 1'b0;
        por_req_n = 1'b0;
        step(40);
        chk("R3", "long request powers down", pump_en, 1'b0);
        chk("R3", "gate_pd on long request", gate_pd, 1'b1);
        out_below_trip = 1'b1;
        step(20);
        chk("R4", "no start while request low", pump_en, 1'b0);
        out_below_trip = 1'b0;
        step(3);
        por_req_n = 1'b1;
        step(20);
        chk("R5", "waits for discharge", pump_en, 1'b0);
        out_below_trip = 1'b1;
        step(10);
        chk("R5", "restart after discharge", pump_en, 1'b1);
    endtask

    task automatic t_uvlo_r9();
        uvlo = 1'b1;
        step(3);
        chk("R9", "pump_en under lockout", pump_en, 1'b0);
        chk("R9", "gate_pd under lockout", gate_pd, 1'b1);
        step(60);
        chk("R9", "still held off", pump_en, 1'b0);
        uvlo = 1'b0;
        step(30);
        chk("R9", "requalifying", pump_en, 1'b0);
        step(18);
        chk("R9", "on after lockout", pump_en, 1'b1);
    endtask

    task automatic t_mid_reset_r10();
        rst_n = 1'b0;
        step(1);
        chk("R10", "pump_en on mid-run reset", pump_en, 1'b0);
        chk("R10", "fault_n on mid-run reset", fault_n, 1'b1);
        rst_n = 1'b1;
        step(2);
    endtask

    initial begin
        step(1);
        t_reset_r10();
        t_insert_r1();
        t_remove_r2();
        t_oc_glitch_r6();
        t_oc_trip_r7_r8();
        t_por_short_r3();
        t_por_long_r3_r4_r5();
        t_uvlo_r9();
        t_mid_reset_r10();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(TCLK * 200000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule